// File: doc/BRIEF.md
# Indirect Byte-Lane Register Port

This block is a 16-bit host-side slave that reaches a small internal register file through only two bus locations. The host first writes a command word to the command location; that word carries a one-hot or paired byte-enable nibble in its top four bits and a byte offset in its low bits. Any number of later accesses to the data location then read or write the byte lanes of the 32-bit register group that the latched command selects. No direct address decode exists: the latched command is the only route to a register.

The byte-enable nibble picks either a single byte lane (8-bit access) or one half of the 32-bit group (16-bit access). The block steers write data into the selected lanes, keeps all other lanes unchanged, and aligns read data onto the 16-bit bus. One register group holds a fixed, read-only identification word. A host probing for the block can tell it is present because that word never reads as all ones.

Top module: `idx_reg_port`

## Requirements
- R1: After reset, `host_rdata` is zero, no command is latched and every writable register group holds zero.
- R2: A write with `host_sel`=1, `host_loc`=1 latches the command word: bits 15..12 are the byte enables (bit 12 = lane 0, bit 15 = lane 3) and bits OFF_W-1..0 are the byte offset. The command stays latched, unchanged, across any number of data accesses until the next command write.
- R3: While no command has been latched since reset, a data write changes no register and a data read returns zero.
- R4: Byte enables 4'b0011 select the low halfword (bits 15..0) of the group and 4'b1100 the high halfword (bits 31..16); a data read returns that halfword on `host_rdata[15:0]`, and a data write stores `host_wdata[15:0]` there and leaves the other halfword unchanged.
- R5: A one-hot byte enable for lane k performs an 8-bit write: the byte is taken from `host_wdata[15:8]` when k is odd and from `host_wdata[7:0]` when k is even, and only lane k of the group changes.
- R6: A one-hot byte enable for lane k performs an 8-bit read: the lane byte appears on `host_rdata[15:8]` with bits 7..0 zero when k is odd, and on `host_rdata[7:0]` with bits 15..8 zero when k is even.
- R7: The register group is chosen by offset bits OFF_W-1..2 only; offset bits 1..0 do not affect which group is accessed.
- R8: Group ID_GROUP is read-only: its low halfword reads as ID_WORD (default 16'hA5C2, never all ones), its high halfword reads as zero, and data writes to it change nothing.
- R9: Any byte-enable pattern other than a single lane, 4'b0011 or 4'b1100 (including 4'b0000) makes a data write change nothing and a data read return zero.
- R10: `host_rdata` is registered: it takes the new value on the clock edge that samples a data read and holds its value through command accesses, data writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_sel | input | 1 | Access strobe, one access per cycle while high |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_loc | input | 1 | 1 = command location, 0 = data location |
| host_wdata | input | 16 | Write data or command word |
| host_rdata | output | 16 | Registered read data from the data location |

## Verification
The lane logic is tried with every single-lane enable, both halfword enables and several illegal nibbles, each as read and as write, so that a swapped lane, a wrong byte source half or a write that leaks into a neighbour lane shows as a wrong byte in a later halfword read. Accesses before any command and accesses to the identification group separate gating by command state from gating by group. Offsets with non-zero low bits show that only the group bits steer the access, and repeated data accesses under one command show the command persists. A seeded random mix of commands, reads and writes then runs against a bench model of the register groups.

// File: rtl/irp_pkg.sv
package irp_pkg;

    localparam int CMD_OFF_W = 12;

    // latched command: valid flag, byte enables, byte offset
    typedef struct packed {
        logic                 vld;
        logic [3:0]           be;
        logic [CMD_OFF_W-1:0] off;
    } cmd_t;

    // decoded lane selection
    typedef struct packed {
        logic       ok;
        logic       half;
        logic [3:0] mask;
        logic [1:0] lane;
    } lanes_t;

endpackage

// File: rtl/irp_cmd_latch.sv
module irp_cmd_latch
    import irp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [15:0] word,
    output cmd_t        cmd
);

    typedef struct packed {
        cmd_t cmd;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cmd.vld = 1'b1;
            st_d.cmd.be  = word[15:12];
            st_d.cmd.off = word[CMD_OFF_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd = st_q.cmd;

endmodule

// File: rtl/irp_lane_dec.sv
module irp_lane_dec
    import irp_pkg::*;
(
    input  logic [3:0]  be,
    input  logic [15:0] wdata,
    input  logic [31:0] rword,
    output lanes_t      lanes,
    output logic [31:0] wbytes,
    output logic [15:0] rdata_fmt
);

    logic [7:0] wbyte;
    logic [7:0] rbyte;

    // byte enable nibble to lane selection
    always_comb begin
        lanes = '0;
        unique case (be)
            4'b0001: begin lanes.ok = 1'b1; lanes.mask = be; lanes.lane = 2'd0; end
            4'b0010: begin lanes.ok = 1'b1; lanes.mask = be; lanes.lane = 2'd1; end
            4'b0100: begin lanes.ok = 1'b1; lanes.mask = be; lanes.lane = 2'd2; end
            4'b1000: begin lanes.ok = 1'b1; lanes.mask = be; lanes.lane = 2'd3; end
            4'b0011: begin lanes.ok = 1'b1; lanes.half = 1'b1; lanes.mask = be; lanes.lane = 2'd0; end
            4'b1100: begin lanes.ok = 1'b1; lanes.half = 1'b1; lanes.mask = be; lanes.lane = 2'd2; end
            default: lanes = '0;
        endcase
    end

    // write steering: odd lanes take the upper bus byte
    always_comb begin
        wbyte = lanes.lane[0] ? wdata[15:8] : wdata[7:0];
        if (lanes.half) begin
            wbytes = {wdata, wdata};
        end else begin
            wbytes = {4{wbyte}};
        end
    end

    // read alignment onto the 16-bit bus
    always_comb begin
        rbyte     = rword[{lanes.lane, 3'b000} +: 8];
        rdata_fmt = '0;
        if (lanes.ok) begin
            if (lanes.half) begin
                rdata_fmt = lanes.lane[1] ? rword[31:16] : rword[15:0];
            end else if (lanes.lane[0]) begin
                rdata_fmt = {rbyte, 8'h00};
            end else begin
                rdata_fmt = {8'h00, rbyte};
            end
        end
    end

endmodule

// File: rtl/irp_regfile.sv
module irp_regfile #(
    parameter int          GROUPS   = 8,
    parameter int          ID_GROUP = 0,
    parameter logic [15:0] ID_WORD  = 16'hA5C2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [$clog2(GROUPS)-1:0] grp,
    input  logic [3:0]                mask,
    input  logic [31:0]               wbytes,
    output logic [31:0]               rword
);

    localparam int GRP_W = $clog2(GROUPS);

    logic [31:0] words [GROUPS];

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        if (g == ID_GROUP) begin : g_id
            assign words[g] = {16'h0000, ID_WORD};
        end else begin : g_rw
            logic [31:0] word_d, word_q;
            logic        hit;

            assign hit = we && (grp == GRP_W'(g));

            always_comb begin
                word_d = word_q;
                for (int b = 0; b < 4; b++) begin
                    if (hit && mask[b]) begin
                        word_d[b*8 +: 8] = wbytes[b*8 +: 8];
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else begin
                    word_q <= word_d;
                end
            end

            assign words[g] = word_q;
        end
    end

    assign rword = words[grp];

endmodule

// File: rtl/idx_reg_port.sv
module idx_reg_port #(
    parameter int          GROUPS   = 8,
    parameter int          ID_GROUP = 0,
    parameter logic [15:0] ID_WORD  = 16'hA5C2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_sel,
    input  logic        host_wr,
    input  logic        host_loc,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata
);
    import irp_pkg::*;

    localparam int GRP_W = $clog2(GROUPS);
    localparam int OFF_W = GRP_W + 2;

    typedef struct packed {
        logic [15:0] rdata;
    } state_t;

    state_t st_d, st_q;

    cmd_t             cmd;
    lanes_t           lanes;
    logic [31:0]      wbytes;
    logic [31:0]      rword;
    logic [15:0]      rdata_fmt;
    logic [GRP_W-1:0] grp;
    logic             cmd_ld;
    logic             data_rd;
    logic             data_we;
    logic             unused_off_bits;

    assign cmd_ld  = host_sel && host_loc && host_wr;
    assign data_rd = host_sel && !host_loc && !host_wr;
    assign data_we = host_sel && !host_loc && host_wr && cmd.vld && lanes.ok;
    assign grp     = cmd.off[OFF_W-1:2];

    assign unused_off_bits = ^{cmd.off[CMD_OFF_W-1:OFF_W], cmd.off[1:0]};

    irp_cmd_latch u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cmd_ld),
        .word  (host_wdata),
        .cmd   (cmd)
    );

    irp_lane_dec u_lane (
        .be        (cmd.be),
        .wdata     (host_wdata),
        .rword     (rword),
        .lanes     (lanes),
        .wbytes    (wbytes),
        .rdata_fmt (rdata_fmt)
    );

    irp_regfile #(
        .GROUPS   (GROUPS),
        .ID_GROUP (ID_GROUP),
        .ID_WORD  (ID_WORD)
    ) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (data_we),
        .grp    (grp),
        .mask   (lanes.mask),
        .wbytes (wbytes),
        .rword  (rword)
    );

    always_comb begin
        st_d = st_q;
        if (data_rd) begin
            st_d.rdata = cmd.vld ? rdata_fmt : 16'h0000;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata = st_q.rdata;

endmodule

// File: rtl/irp_checker.sv
module irp_checker #(
    parameter int          GROUPS   = 8,
    parameter int          ID_GROUP = 0,
    parameter logic [15:0] ID_WORD  = 16'hA5C2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      host_sel,
    input logic                      host_wr,
    input logic                      host_loc,
    input logic [15:0]               host_rdata,
    input logic                      cmd_vld,
    input logic [3:0]                cmd_be,
    input logic [$clog2(GROUPS)-1:0] cmd_grp
);
    localparam int GRP_W = $clog2(GROUPS);

    logic rd_acc, cmd_wr, be_ok;
    assign rd_acc = host_sel && !host_loc && !host_wr;
    assign cmd_wr = host_sel && host_loc && host_wr;
    assign be_ok  = (cmd_be inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100});

    assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!cmd_vld && host_rdata == 16'h0000));

    assert_cmd_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> ($stable(cmd_vld) && $stable(cmd_be) && $stable(cmd_grp)));

    assert_nocmd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && !cmd_vld) |=> (host_rdata == 16'h0000));

    assert_odd_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && cmd_vld && (cmd_be == 4'b0010 || cmd_be == 4'b1000)) |=> (host_rdata[7:0] == 8'h00));

    assert_even_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && cmd_vld && (cmd_be == 4'b0001 || cmd_be == 4'b0100)) |=> (host_rdata[15:8] == 8'h00));

    assert_id_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && cmd_vld && cmd_grp == GRP_W'(ID_GROUP) && cmd_be == 4'b0011) |=> (host_rdata == ID_WORD));

    assert_bad_be_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && cmd_vld && !be_ok) |=> (host_rdata == 16'h0000));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(host_rdata));

endmodule

bind idx_reg_port irp_checker #(
    .GROUPS   (GROUPS),
    .ID_GROUP (ID_GROUP),
    .ID_WORD  (ID_WORD)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_loc   (host_loc),
    .host_rdata (host_rdata),
    .cmd_vld    (cmd.vld),
    .cmd_be     (cmd.be),
    .cmd_grp    (grp)
);

// File: tb/idx_reg_port_tb.sv
module idx_reg_port_tb_top;

    localparam int          GROUPS   = 8;
    localparam int          ID_GROUP = 0;
    localparam logic [15:0] ID_WORD  = 16'hA5C2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_loc = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench model
    logic [31:0] mdl [GROUPS];
    bit          m_vld = 1'b0;
    logic [3:0]  m_be  = '0;
    logic [4:0]  m_off = '0;

    always #5 clk = ~clk;

    idx_reg_port #(
        .GROUPS   (GROUPS),
        .ID_GROUP (ID_GROUP),
        .ID_WORD  (ID_WORD)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_loc   (host_loc),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    function automatic logic [15:0] exp_rd(logic [3:0] be, logic [4:0] off);
        logic [31:0] w;
        int g;
        if (!m_vld) return 16'h0000;
        g = int'(off[4:2]);
        w = (g == ID_GROUP) ? {16'h0000, ID_WORD} : mdl[g];
        case (be)
            4'b0011: return w[15:0];
            4'b1100: return w[31:16];
            4'b0001: return {8'h00, w[7:0]};
            4'b0010: return {w[15:8], 8'h00};
            4'b0100: return {8'h00, w[23:16]};
            4'b1000: return {w[31:24], 8'h00};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic mdl_wr(logic [15:0] d);
        int g;
        if (!m_vld) return;
        g = int'(m_off[4:2]);
        if (g == ID_GROUP) return;
        case (m_be)
            4'b0011: mdl[g][15:0]  = d;
            4'b1100: mdl[g][31:16] = d;
            4'b0001: mdl[g][7:0]   = d[7:0];
            4'b0010: mdl[g][15:8]  = d[15:8];
            4'b0100: mdl[g][23:16] = d[7:0];
            4'b1000: mdl[g][31:24] = d[15:8];
            default: ;
        endcase
    endtask

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(bit loc, bit wr, logic [15:0] d);
        @(negedge clk);
        host_sel   = 1'b1;
        host_loc   = loc;
        host_wr    = wr;
        host_wdata = d;
        @(negedge clk);
        host_sel   = 1'b0;
        host_wdata = '0;
    endtask

    task automatic cmd(logic [3:0] be, logic [4:0] off);
        access(1'b1, 1'b1, {be, 7'b0, off});
        m_vld = 1'b1;
        m_be  = be;
        m_off = off;
    endtask

    task automatic wr(logic [15:0] d);
        access(1'b0, 1'b1, d);
        mdl_wr(d);
    endtask

    task automatic rd(string tag, logic [15:0] exp);
        access(1'b0, 1'b0, 16'h0000);
        chk(tag, host_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [3:0]  pats [8];
        logic [15:0] hold;
        int unsigned r;
        pats = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b0000, 4'b0110};
        for (int g = 0; g < GROUPS; g++) mdl[g] = '0;
        r = $urandom(32'd2024);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset rdata", host_rdata, 16'h0000);

        // R3: no command yet
        access(1'b0, 1'b1, 16'hBEEF);
        access(1'b0, 1'b0, 16'h0000);
        chk("R3 read before command", host_rdata, 16'h0000);
        cmd(4'b0011, {3'd1, 2'b00});
        rd("R3 early write ignored / R1 cleared group", 16'h0000);

        // R4 halfwords
        wr(16'h1234);
        cmd(4'b1100, {3'd1, 2'b10});
        wr(16'hABCD);
        rd("R4 high half", 16'hABCD);
        cmd(4'b0011, {3'd1, 2'b00});
        rd("R4 low half untouched", 16'h1234);

        // R5/R6 byte lanes
        cmd(4'b0010, {3'd1, 2'b01});
        wr(16'h7788);
        rd("R6 odd lane read", 16'h7700);
        cmd(4'b0011, {3'd1, 2'b00});
        rd("R5 odd lane write from upper byte", 16'h7734);
        cmd(4'b0100, {3'd1, 2'b10});
        wr(16'h55AA);
        rd("R6 even lane read", 16'h00AA);
        cmd(4'b1100, {3'd1, 2'b10});
        rd("R5 even lane write from lower byte", 16'hABAA);

        // R2 persistence across data accesses
        cmd(4'b0011, {3'd2, 2'b00});
        wr(16'h1111);
        rd("R2 first read", 16'h1111);
        wr(16'h2222);
        rd("R2 command kept", 16'h2222);

        // R7 low offset bits ignored
        cmd(4'b0011, {3'd2, 2'b11});
        rd("R7 low offset bits", 16'h2222);

        // R8 identification group
        cmd(4'b0011, {3'(ID_GROUP), 2'b00});
        rd("R8 id word", ID_WORD);
        wr(16'hFFFF);
        rd("R8 id write ignored", ID_WORD);
        cmd(4'b1100, {3'(ID_GROUP), 2'b10});
        rd("R8 id high half", 16'h0000);

        // R9 illegal enables
        cmd(4'b0110, {3'd1, 2'b01});
        wr(16'hFFFF);
        rd("R9 illegal read", 16'h0000);
        cmd(4'b0000, {3'd1, 2'b00});
        wr(16'hFFFF);
        rd("R9 empty enables", 16'h0000);
        cmd(4'b0011, {3'd1, 2'b00});
        rd("R9 illegal write ignored", 16'h7734);

        // R10 hold
        hold = host_rdata;
        cmd(4'b0011, {3'd3, 2'b00});
        chk("R10 hold after command", host_rdata, hold);
        wr(16'h4242);
        chk("R10 hold after write", host_rdata, hold);
        repeat (3) @(negedge clk);
        chk("R10 hold idle", host_rdata, hold);

        // seeded random mix, R4 R5 R6 R9
        for (int i = 0; i < 600; i++) begin
            r = $urandom;
            if (r[3:0] < 4'd4) begin
                cmd(pats[r[6:4]], r[11:7]);
            end else if (r[3:0] < 4'd10) begin
                wr(r[31:16]);
            end else begin
                rd("R4/R5/R6/R9 random read", exp_rd(m_be, m_off));
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule